// File: doc/BRIEF.md
# TDM Channel Slot Multiplexer

This block connects the first four 8-bit channels of a framed time-division serial stream to local registers and to one PCM datapath. A frame holds 32 channels of 8 bits, one bit per clock, and a frame pulse marks bit 0 of channel 0. Channel 1 carries a control/status byte. On transmit it comes from a writable register and is gated by an enable bit. On receive it is always captured into a readable register. Channels 2 and 3 are two bearer slots. Separate transmit and receive select bits choose which of the two the PCM datapath uses in each direction. Channel 0 and channels 4 to 31 are never driven.

The transmit stream is a data bit plus a drive-enable. A pad outside the block turns it into a tri-state line. Software reaches the control register and the control-channel byte through a small address/data port. A self-clearing soft-reset bit puts the control-channel transmit byte back to all ones.

Top module: `tdm_slot_mux`

## Requirements
- R1: While the block is in reset, and after reset until the first write, both registers read 0 and `tx_en` is low. The control-channel transmit byte is 0xFF, so enabling the control slot sends 0xFF.
- R2: When control bit 0 (control-slot enable) is 1, channel 1 is driven with the byte last written to address 5, most significant bit in frame bit 0 of the slot.
- R3: When control bit 0 is 0, `tx_en` is low throughout channel 1. Whenever `tx_en` is low, `tx_bit` is 0.
- R4: The 8 bits received in channel 1 (first bit is the MSB) are readable at address 5 from the cycle after the slot's last bit, whatever the value of control bit 0.
- R5: Writing address 3 with bit 7 set makes bit 7 read 1 for exactly the next cycle. In the cycle after that the control-channel transmit byte is 0xFF. This overrides a write to address 5 made in that same cycle.
- R6: With control bit 1 (transmit path enable) set, the PCM byte `pcm_tx` is sent MSB first in channel 2 if control bit 2 is 0, or in channel 3 if it is 1. The other bearer slot is not driven.
- R7: With control bit 1 clear, neither channel 2 nor channel 3 is driven.
- R8: The byte received in channel 2 (control bit 3 = 0) or channel 3 (bit 3 = 1) appears on `pcm_rx`, and `pcm_rx_valid` pulses for one cycle, in the cycle after that slot's last bit. This does not depend on the transmit selections.
- R9: Channels 0 and 4 to 31 are never driven. Before the first frame pulse after reset, nothing is driven or captured.
- R10: The frame pulse cycle is bit 0 of channel 0, and the position then advances one bit per clock. Without a new pulse it wraps to channel 0 after 256 bits. An early pulse realigns the frame at once.
- R11: Address 3 reads back {soft-reset bit, three zeros, bits 3..0 as written}. Address 5 reads the received control byte. All other addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one stream bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | High in the cycle of bit 0 of channel 0 |
| rx_bit | input | 1 | Incoming serial stream |
| tx_bit | output | 1 | Outgoing serial data, 0 when not driven |
| tx_en | output | 1 | Drive enable for the outgoing stream |
| pcm_tx | input | 8 | PCM byte to transmit, held over its slot |
| pcm_rx | output | 8 | Last PCM byte received |
| pcm_rx_valid | output | 1 | One-cycle pulse when `pcm_rx` updates |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |

## Verification
The stream is exercised in several ways. Directed frames with each combination of enable and select bits separate the gated control slot, the two bearer slots and the silent channels. Frames with a missing pulse and with an early pulse separate a free-running counter from one that realigns. Soft-reset writes, alone and followed at once by a control-byte write, show whether the reset bit pulses once and wins. Random frames with random register writes at random bit positions catch capture or transmit errors that depend on where in a slot a control change lands.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;
  localparam int SLOT_CTL    = 1;
  localparam int SLOT_BEARER = 2;
  localparam int ADDR_CTRL   = 3;
  localparam int ADDR_CBYTE  = 5;

  typedef struct packed {
    logic rx_b_sel;
    logic tx_b_sel;
    logic tx_path_en;
    logic ctl_en;
  } ctrl_t;
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int SLOT_W    = 8,
  parameter int NUM_SLOTS = 32,
  localparam int BIT_W    = $clog2(SLOT_W),
  localparam int CH_W     = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_sync,
  output logic             active,
  output logic [CH_W-1:0]  ch,
  output logic [BIT_W-1:0] bitn
);
  localparam int POS_W = BIT_W + CH_W;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(SLOT_W * NUM_SLOTS - 1);

  logic [POS_W-1:0] cnt_q, cnt_d, pos;
  logic             lock_q, lock_d;

  always_comb begin
    pos    = frame_sync ? '0 : cnt_q;
    active = frame_sync | lock_q;
    lock_d = active;
    cnt_d  = (pos == POS_LAST) ? '0 : pos + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (active) begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign ch   = pos[POS_W-1:BIT_W];
  assign bitn = pos[BIT_W-1:0];
endmodule

// File: rtl/tdm_slot_regs.sv
module tdm_slot_regs
  import tdm_slot_pkg::*;
#(
  parameter int SLOT_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [SLOT_W-1:0] reg_wdata,
  input  logic [SLOT_W-1:0] ctl_rx,
  output ctrl_t             ctrl,
  output logic              srst,
  output logic [SLOT_W-1:0] ctl_tx,
  output logic [SLOT_W-1:0] reg_rdata
);
  localparam int CW = $bits(ctrl_t);

  ctrl_t             ctrl_q, ctrl_d;
  logic              srst_q, srst_d;
  logic [SLOT_W-1:0] ctl_tx_q, ctl_tx_d;
  logic              wr_ctrl, wr_cbyte;

  always_comb begin
    wr_ctrl  = reg_we && (reg_addr == ADDR_W'(ADDR_CTRL));
    wr_cbyte = reg_we && (reg_addr == ADDR_W'(ADDR_CBYTE));
    ctrl_d   = wr_ctrl ? ctrl_t'(reg_wdata[CW-1:0]) : ctrl_q;
    srst_d   = wr_ctrl & reg_wdata[SLOT_W-1];
    if (srst_q)        ctl_tx_d = '1;
    else if (wr_cbyte) ctl_tx_d = reg_wdata;
    else               ctl_tx_d = ctl_tx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      srst_q   <= 1'b0;
      ctl_tx_q <= '1;
    end else begin
      ctrl_q   <= ctrl_d;
      srst_q   <= srst_d;
      ctl_tx_q <= ctl_tx_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADDR_CTRL))
      reg_rdata = {srst_q, {(SLOT_W-CW-1){1'b0}}, ctrl_q};
    else if (reg_addr == ADDR_W'(ADDR_CBYTE))
      reg_rdata = ctl_rx;
  end

  assign ctrl   = ctrl_q;
  assign srst   = srst_q;
  assign ctl_tx = ctl_tx_q;
endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
  import tdm_slot_pkg::*;
#(
  parameter int SLOT_W    = 8,
  parameter int NUM_SLOTS = 32,
  localparam int BIT_W    = $clog2(SLOT_W),
  localparam int CH_W     = $clog2(NUM_SLOTS)
) (
  input  logic              active,
  input  logic [CH_W-1:0]   ch,
  input  logic [BIT_W-1:0]  bitn,
  input  ctrl_t             ctrl,
  input  logic [SLOT_W-1:0] ctl_tx,
  input  logic [SLOT_W-1:0] pcm_tx,
  output logic              tx_bit,
  output logic              tx_en
);
  localparam logic [BIT_W-1:0] MSB_IDX = BIT_W'(SLOT_W - 1);

  logic [BIT_W-1:0] idx;
  logic [CH_W-1:0]  b_slot;

  always_comb begin
    idx    = MSB_IDX - bitn;
    b_slot = CH_W'(SLOT_BEARER) + CH_W'(ctrl.tx_b_sel);
    tx_en  = 1'b0;
    tx_bit = 1'b0;
    if (active) begin
      if (ch == CH_W'(SLOT_CTL)) begin
        tx_en  = ctrl.ctl_en;
        tx_bit = ctrl.ctl_en & ctl_tx[idx];
      end else if (ctrl.tx_path_en && (ch == b_slot)) begin
        tx_en  = 1'b1;
        tx_bit = pcm_tx[idx];
      end
    end
  end
endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
  import tdm_slot_pkg::*;
#(
  parameter int SLOT_W    = 8,
  parameter int NUM_SLOTS = 32,
  localparam int BIT_W    = $clog2(SLOT_W),
  localparam int CH_W     = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [CH_W-1:0]   ch,
  input  logic [BIT_W-1:0]  bitn,
  input  logic              rx_bit,
  input  logic              rx_b_sel,
  output logic [SLOT_W-1:0] ctl_rx,
  output logic [SLOT_W-1:0] pcm_rx,
  output logic              pcm_rx_valid
);
  localparam logic [BIT_W-1:0] MSB_IDX = BIT_W'(SLOT_W - 1);

  logic [SLOT_W-1:0] sh_q, ctl_q, pcm_q, full;
  logic              valid_q, slot_end, ctl_hit, b_hit;

  always_comb begin
    full     = {sh_q[SLOT_W-2:0], rx_bit};
    slot_end = active && (bitn == MSB_IDX);
    ctl_hit  = slot_end && (ch == CH_W'(SLOT_CTL));
    b_hit    = slot_end && (ch == CH_W'(SLOT_BEARER) + CH_W'(rx_b_sel));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      ctl_q   <= '0;
      pcm_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (active)  sh_q  <= full;
      if (ctl_hit) ctl_q <= full;
      if (b_hit)   pcm_q <= full;
      valid_q <= b_hit;
    end
  end

  assign ctl_rx       = ctl_q;
  assign pcm_rx       = pcm_q;
  assign pcm_rx_valid = valid_q;
endmodule

// File: rtl/tdm_slot_mux.sv
module tdm_slot_mux
  import tdm_slot_pkg::*;
#(
  parameter int SLOT_W      = 8,
  parameter int NUM_SLOTS   = 32,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              rx_bit,
  output logic              tx_bit,
  output logic              tx_en,
  input  logic [SLOT_W-1:0] pcm_tx,
  output logic [SLOT_W-1:0] pcm_rx,
  output logic              pcm_rx_valid,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [SLOT_W-1:0] reg_wdata,
  output logic [SLOT_W-1:0] reg_rdata
);
  localparam int BIT_W = $clog2(SLOT_W);
  localparam int CH_W  = $clog2(NUM_SLOTS);

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[SYNC_STAGES-1];

  logic              active;
  logic [CH_W-1:0]   ch;
  logic [BIT_W-1:0]  bitn;
  ctrl_t             ctrl;
  logic              srst;
  logic [SLOT_W-1:0] ctl_tx, ctl_rx;

  tdm_slot_timer #(.SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) u_timer (
    .clk(clk), .rst_n(rst_ni), .frame_sync(frame_sync),
    .active(active), .ch(ch), .bitn(bitn)
  );

  tdm_slot_regs #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_ni), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .ctl_rx(ctl_rx), .ctrl(ctrl), .srst(srst),
    .ctl_tx(ctl_tx), .reg_rdata(reg_rdata)
  );

  tdm_slot_tx #(.SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) u_tx (
    .active(active), .ch(ch), .bitn(bitn), .ctrl(ctrl), .ctl_tx(ctl_tx),
    .pcm_tx(pcm_tx), .tx_bit(tx_bit), .tx_en(tx_en)
  );

  tdm_slot_rx #(.SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) u_rx (
    .clk(clk), .rst_n(rst_ni), .active(active), .ch(ch), .bitn(bitn),
    .rx_bit(rx_bit), .rx_b_sel(ctrl.rx_b_sel), .ctl_rx(ctl_rx),
    .pcm_rx(pcm_rx), .pcm_rx_valid(pcm_rx_valid)
  );
endmodule

// File: rtl/tdm_slot_mux_chk.sv
module tdm_slot_mux_chk
  import tdm_slot_pkg::*;
#(
  parameter int SLOT_W    = 8,
  parameter int NUM_SLOTS = 32,
  parameter int ADDR_W    = 3,
  localparam int BIT_W    = $clog2(SLOT_W),
  localparam int CH_W     = $clog2(NUM_SLOTS)
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              active,
  input logic [CH_W-1:0]   ch,
  input logic [BIT_W-1:0]  bitn,
  input logic              tx_en,
  input ctrl_t             ctrl,
  input logic              srst,
  input logic [SLOT_W-1:0] ctl_tx,
  input logic [SLOT_W-1:0] ctl_rx,
  input logic              pcm_rx_valid,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [SLOT_W-1:0] reg_wdata
);
  logic wr_srst, ctl_end;
  assign wr_srst = reg_we && (reg_addr == ADDR_W'(ADDR_CTRL)) && reg_wdata[SLOT_W-1];
  assign ctl_end = active && (ch == CH_W'(SLOT_CTL)) && (bitn == BIT_W'(SLOT_W - 1));

  p_quiet_slots_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    tx_en |-> active && (ch == CH_W'(1) || ch == CH_W'(2) || ch == CH_W'(3)));

  p_ctl_gate_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (active && ch == CH_W'(SLOT_CTL) && !ctrl.ctl_en) |-> !tx_en);

  p_bearer_sel_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_en && ch != CH_W'(SLOT_CTL)) |->
      (ctrl.tx_path_en && ch == CH_W'(SLOT_BEARER) + CH_W'(ctrl.tx_b_sel)));

  p_ctl_hold_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    !ctl_end |=> $stable(ctl_rx));

  p_srst_clear_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (srst && !wr_srst) |=> !srst);

  p_srst_ones_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    srst |=> (ctl_tx == '1));

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    pcm_rx_valid |=> !pcm_rx_valid);
endmodule

bind tdm_slot_mux tdm_slot_mux_chk #(
  .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_ni(rst_ni), .active(active), .ch(ch), .bitn(bitn),
  .tx_en(tx_en), .ctrl(ctrl), .srst(srst), .ctl_tx(ctl_tx), .ctl_rx(ctl_rx),
  .pcm_rx_valid(pcm_rx_valid), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata)
);

// File: tb/tdm_slot_mux_test.sv
`timescale 1ns/1ps
module tdm_slot_mux_test;
  logic       clk = 1'b0;
  logic       rst_n, frame_sync, rx_bit, reg_we;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, pcm_tx;
  logic       tx_bit, tx_en, pcm_rx_valid;
  logic [7:0] pcm_rx, reg_rdata;

  tdm_slot_mux uut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .rx_bit(rx_bit),
    .tx_bit(tx_bit), .tx_en(tx_en), .pcm_tx(pcm_tx), .pcm_rx(pcm_rx),
    .pcm_rx_valid(pcm_rx_valid), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #4 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model
  logic [3:0] m_ctrl = 4'h0;
  logic       m_srst = 1'b0, m_valid = 1'b0, m_lock = 1'b0;
  logic [7:0] m_ctx = 8'hFF, m_crx = 8'h00, m_pcm = 8'h00, m_sh = 8'h00;
  int         m_cnt = 0;
  logic       nxt_we = 1'b0;
  logic [2:0] nxt_addr = 3'd0, rd_addr = 3'd0;
  logic [7:0] nxt_data = 8'h00;
  string      ovr = "";

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    if (a == 3'd3) return {m_srst, 3'b000, m_ctrl};
    if (a == 3'd5) return m_crx;
    return 8'h00;
  endfunction

  function automatic string tx_tag(input int ch);
    if (ovr != "") return ovr;
    if (ch == 1) return m_ctrl[0] ? "R2" : "R3";
    if (ch == 2 || ch == 3) return m_ctrl[1] ? "R6" : "R7";
    return "R9";
  endfunction

  task automatic step(input bit fs);
    int p, ch, b;
    bit act, e_en, e_bit;
    logic [7:0] full, new_ctx;
    @(negedge clk);
    frame_sync = fs;
    rx_bit     = 1'($urandom);
    reg_we     = nxt_we;
    reg_addr   = nxt_we ? nxt_addr : rd_addr;
    reg_wdata  = nxt_data;
    p   = fs ? 0 : m_cnt;
    act = fs || m_lock;
    ch  = p / 8;
    b   = p % 8;
    if (b == 0) pcm_tx = 8'($urandom);
    #2;
    e_en = 1'b0; e_bit = 1'b0;
    if (act && ch == 1 && m_ctrl[0]) begin
      e_en = 1'b1; e_bit = m_ctx[7-b];
    end else if (act && m_ctrl[1] && ch == 2 + int'(m_ctrl[2])) begin
      e_en = 1'b1; e_bit = pcm_tx[7-b];
    end
    check(tx_en == e_en && tx_bit == e_bit, tx_tag(ch), "tx en/bit",
          {tx_en, tx_bit}, {e_en, e_bit});
    check(pcm_rx_valid == m_valid, "R8", "pcm_rx_valid", pcm_rx_valid, m_valid);
    if (m_valid) check(pcm_rx == m_pcm, "R8", "pcm_rx", pcm_rx, m_pcm);
    if (!reg_we)
      check(reg_rdata == exp_rd(reg_addr),
            (reg_addr == 3'd5) ? "R4" : (m_srst ? "R5" : "R11"),
            "reg_rdata", reg_rdata, exp_rd(reg_addr));
    @(posedge clk);
    full    = {m_sh[6:0], rx_bit};
    m_valid = 1'b0;
    if (act) begin
      m_sh = full;
      if (b == 7 && ch == 1) m_crx = full;
      if (b == 7 && ch == 2 + int'(m_ctrl[3])) begin
        m_pcm = full; m_valid = 1'b1;
      end
      m_lock = 1'b1;
      m_cnt  = (p + 1) % 256;
    end
    new_ctx = m_srst ? 8'hFF : ((reg_we && reg_addr == 3'd5) ? reg_wdata : m_ctx);
    if (reg_we && reg_addr == 3'd3) begin
      m_ctrl = reg_wdata[3:0]; m_srst = reg_wdata[7];
    end else m_srst = 1'b0;
    m_ctx  = new_ctx;
    nxt_we = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    nxt_we = 1'b1; nxt_addr = a; nxt_data = d;
    step(1'b0);
  endtask

  task automatic frame(input int n, input bit sync_first, input bit rand_wr);
    for (int i = 0; i < n; i++) begin
      if (rand_wr && ($urandom % 12) == 0) begin
        nxt_we   = 1'b1;
        nxt_addr = 3'($urandom);
        nxt_data = 8'($urandom);
        if (($urandom % 8) != 0) nxt_data[7] = 1'b0;
      end
      rd_addr = 3'($urandom);
      step(sync_first && i == 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5107_7A3C));
    rst_n = 1'b0; frame_sync = 1'b0; rx_bit = 1'b0; reg_we = 1'b0;
    reg_addr = 3'd0; reg_wdata = 8'h00; pcm_tx = 8'h00;
    // R1: reset state, registers and output
    ovr = "R1";
    for (int i = 0; i < 4; i++) begin rd_addr = 3'(i + 2); step(1'b0); end
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin rd_addr = (i % 2) ? 3'd3 : 3'd5; step(1'b0); end
    // R9: unlocked stream drives nothing even with slots enabled
    ovr = "R9";
    wr(3'd3, 8'h03);
    frame(20, 1'b0, 1'b0);
    // R1: reset value 0xFF appears in the control slot
    ovr = "R1";
    frame(256, 1'b1, 1'b0);
    ovr = "";
    // R2 R6: control byte and bearer B1, then B2 with receive on B1
    wr(3'd5, 8'hA5);
    frame(256, 1'b1, 1'b0);
    wr(3'd3, 8'h07);
    frame(256, 1'b1, 1'b0);
    wr(3'd3, 8'h0B);
    frame(256, 1'b1, 1'b0);
    // R3 R7 R4: everything off, receive still captured
    wr(3'd3, 8'h08);
    rd_addr = 3'd5;
    frame(256, 1'b1, 1'b0);
    // R5: soft reset alone, then overriding a same-cycle byte write
    ovr = "R5";
    wr(3'd5, 8'h00);
    wr(3'd3, 8'h81);
    rd_addr = 3'd3; step(1'b0); step(1'b0);
    frame(256, 1'b1, 1'b0);
    wr(3'd3, 8'h81);
    wr(3'd5, 8'h3C);
    frame(256, 1'b1, 1'b0);
    // R11: writes to unmapped addresses change nothing
    ovr = "R11";
    wr(3'd2, 8'h55); wr(3'd7, 8'hAA); wr(3'd0, 8'hFF);
    rd_addr = 3'd3; step(1'b0); rd_addr = 3'd5; step(1'b0);
    rd_addr = 3'd7; step(1'b0);
    // R10: wrap without a pulse, then an early pulse realigns
    ovr = "R10";
    wr(3'd3, 8'h03);
    frame(256, 1'b1, 1'b0);
    frame(256, 1'b0, 1'b0);
    frame(100, 1'b1, 1'b0);
    frame(256, 1'b1, 1'b0);
    ovr = "";
    // random register traffic over free frames
    for (int f = 0; f < 10; f++) frame(256, 1'b1, 1'b1);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 60000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule